// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes over the row strobe, column strobe, write enable and address lines of an asynchronous DRAM whenever the access controller hands it the bus. Out of reset it waits out the mandatory power-up pause. It then runs a fixed number of warm-up refresh cycles and raises `init_done`. From then on it keeps the array alive: a timer posts one refresh per interval, and enough intervals fit in the retention period to visit every row.

Each refresh cycle uses one of two forms, chosen by `mode_ro` when the cycle starts. The first form drops the column strobe before the row strobe, so the device picks the row from its own counter, and write enable stays high so that the cycle cannot be taken for a test-mode entry. The second form keeps the column strobe high and drives the row address from a counter inside the block, which advances once per cycle of this kind. Requests and grants pass through a simple handshake. Refreshes whose grant is late queue up to a small limit, and any overflow beyond that limit sets a sticky missed-deadline flag.

Timing values are parameters counted in clock cycles. The defaults assume a 50 MHz clock: a 200 µs pause, a 15 µs refresh interval and 4096 rows.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and directly after reset, ras_n, cas_n and we_n are 1, bus_own, ref_req, init_done and miss_err are 0, and addr is 0.
- R2: ref_req first rises exactly PAUSE_CYC clock cycles after reset is released, and bus_own stays 0 during the pause even while ref_gnt is held high.
- R3: A refresh cycle starts only at a clock edge where ref_req and ref_gnt are both 1. bus_own is 1 for exactly CYC_LEN = T_CSR+T_RAS+T_RP cycles starting on the following cycle, and ref_req is 0 throughout.
- R4: init_done rises on the cycle after the last precharge cycle of the INIT_CYCLES-th completed refresh cycle and stays 1 until reset.
- R5: With mode_ro = 0, cas_n is 0 for T_CSR cycles while ras_n is 1. ras_n is then 0 for T_RAS cycles, with cas_n still 0 for the first T_CHR of them and 1 for the rest. Both are then 1 for T_RP cycles. we_n is 1 and addr is 0 for the whole cycle.
- R6: With mode_ro = 1, cas_n is 1 for the whole cycle, ras_n follows the same T_CSR/T_RAS/T_RP pattern, and addr carries the internal row number in every owned cycle.
- R7: The internal row number is 0 after reset and advances by one after each row-addressed cycle, wrapping from ROWS-1 to 0. Cycles where the device counts rows do not move it.
- R8: mode_ro is sampled only at the edge that starts a cycle. A change during a cycle does not alter that cycle's waveform.
- R9: After init_done rises, the timer posts one refresh every REFI_CYC cycles. The first ref_req rises exactly REFI_CYC cycles after init_done.
- R10: Up to PEND_MAX refreshes queue while the grant is withheld. Once the grant is held, all of them run back to back, after which ref_req falls.
- R11: miss_err sets when the timer posts a refresh while PEND_MAX are already waiting, and stays 1 until reset.
- R12: Whenever bus_own is 0, ras_n, cas_n and we_n are 1 and addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_ro | input | 1 | Refresh form: 0 = column strobe first (device counts rows), 1 = row address supplied |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Request for the bus; a refresh is waiting |
| bus_own | output | 1 | The block is driving the DRAM lines |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address in row-addressed cycles, else 0 |
| init_done | output | 1 | Power-up sequence complete |
| miss_err | output | 1 | Sticky flag: the refresh backlog overflowed |

## Verification
The missed-deadline flag is the hardest state to reach from the ports. It needs PEND_MAX+1 timer posts with the grant held low the whole time, and it must not fire one interval earlier. The bench therefore shrinks the interval, holds the grant low and counts cycles from the first request to the exact edges where the flag must still be clear and then set. It then grants the bus and counts the back-to-back drain. The row wrap is reached the same way, with a small ROWS so that a full lap of the row-addressed cycles fits in the run.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } sq_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_e;

endpackage

// File: rtl/drs_init_ctl.sv
// Power-up pause followed by a fixed number of warm-up refresh cycles.
module drs_init_ctl
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC   = 10000,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done,
  output logic init_active,
  output logic init_done
);

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_CYCLES - 1);

  phase_e          phase_q, phase_d;
  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic [IW-1:0]   icnt_q, icnt_d;
  logic            pcnt_en, icnt_en;

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    icnt_d  = icnt_q;
    pcnt_en = 1'b0;
    icnt_en = 1'b0;
    case (phase_q)
      PH_PAUSE: begin
        pcnt_en = 1'b1;
        if (pcnt_q == PAUSE_LAST) begin
          phase_d = PH_INIT;
          pcnt_d  = '0;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      PH_INIT: begin
        if (cyc_done) begin
          icnt_en = 1'b1;
          if (icnt_q == INIT_LAST) begin
            phase_d = PH_RUN;
            icnt_d  = '0;
          end else begin
            icnt_d = icnt_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      pcnt_q  <= '0;
      icnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (pcnt_en) pcnt_q <= pcnt_d;
      if (icnt_en) icnt_q <= icnt_d;
    end
  end

  assign init_active = (phase_q == PH_INIT);
  assign init_done   = (phase_q == PH_RUN);

endmodule

// File: rtl/drs_interval.sv
// Refresh interval timer with a bounded backlog and a sticky overflow flag.
module drs_interval #(
  parameter int REFI_CYC = 750,
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic accept,
  output logic pend_nz,
  output logic miss_err
);

  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int NW = $clog2(PEND_MAX + 1);
  localparam logic [TW-1:0] TICK_AT  = TW'(REFI_CYC - 1);
  localparam logic [NW-1:0] PEND_TOP = NW'(PEND_MAX);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [NW-1:0] pend_q, pend_d;
  logic          err_q, err_d;
  logic          tick;

  always_comb begin
    tick   = run_en && (tcnt_q == TICK_AT);
    tcnt_d = tick ? '0 : tcnt_q + 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    err_d  = err_q;
    case ({tick, accept})
      2'b10: begin
        if (pend_q == PEND_TOP) err_d = 1'b1;
        else                    pend_d = pend_q + 1'b1;
      end
      2'b01:   pend_d = pend_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (run_en) tcnt_q <= tcnt_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign pend_nz  = (pend_q != '0);
  assign miss_err = err_q;

endmodule

// File: rtl/drs_row_ctr.sv
// Row number driven in row-addressed refresh cycles.
module drs_row_ctr #(
  parameter int ROWS  = 4096,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= row_d;
  end

  assign row = row_q;

endmodule

// File: rtl/drs_strobe_seq.sv
// Strobe sequencer for one refresh cycle: setup, active, precharge.
// All strobes are registered from the next-state decode.
module drs_strobe_seq
  import drs_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 3,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_ro,
  input  logic [ROW_W-1:0] row,
  output logic             ras_n,
  output logic             cas_n,
  output logic             bus_own,
  output logic [ROW_W-1:0] addr,
  output logic             idle,
  output logic             cyc_done,
  output logic             ro_cycle
);

  localparam int MAX_A = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int MAX_D = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int CW    = $clog2(MAX_D + 1);
  localparam logic [CW-1:0] LD_CSR   = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LD_RAS   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_EDGE = CW'(T_RAS - T_CHR);

  sq_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ro_q, ro_d;
  logic             ld_mode;
  logic             ras_q, ras_d;
  logic             cas_q, cas_d;
  logic             own_q, own_d;
  logic [ROW_W-1:0] addr_q, addr_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ld_mode = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_SETUP;
          cnt_d   = LD_CSR;
          ld_mode = 1'b1;
        end
      end
      SQ_SETUP: begin
        if (cnt_q == '0) begin
          state_d = SQ_ACT;
          cnt_d   = LD_RAS;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_ACT: begin
        if (cnt_q == '0) begin
          state_d = SQ_PRE;
          cnt_d   = LD_RP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_PRE: begin
        if (cnt_q == '0) state_d = SQ_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
    ro_d = ld_mode ? mode_ro : ro_q;
  end

  // Output decode from the next state
  always_comb begin
    own_d  = (state_d != SQ_IDLE);
    ras_d  = (state_d != SQ_ACT);
    cas_d  = !(!ro_d && ((state_d == SQ_SETUP) ||
                         ((state_d == SQ_ACT) && (cnt_d >= CHR_EDGE))));
    addr_d = (own_d && ro_d) ? row : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      ro_q    <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      own_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (ld_mode) ro_q <= ro_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
      own_q   <= own_d;
      addr_q  <= addr_d;
    end
  end

  assign ras_n    = ras_q;
  assign cas_n    = cas_q;
  assign bus_own  = own_q;
  assign addr     = addr_q;
  assign idle     = (state_q == SQ_IDLE);
  assign cyc_done = (state_q == SQ_PRE) && (cnt_q == '0);
  assign ro_cycle = ro_q;

endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM refresh and power-up sequencer: top level.
module dram_refresh_seq #(
  parameter int ROWS        = 4096,
  parameter int REFI_CYC    = 750,
  parameter int PAUSE_CYC   = 10000,
  parameter int INIT_CYCLES = 8,
  parameter int PEND_MAX    = 4,
  parameter int T_CSR       = 1,
  parameter int T_CHR       = 1,
  parameter int T_RAS       = 3,
  parameter int T_RP        = 2,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ro,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             bus_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic             init_done,
  output logic             miss_err
);

  logic             init_active;
  logic             pend_nz;
  logic             seq_idle;
  logic             cyc_done;
  logic             ro_cycle;
  logic             start;
  logic             accept;
  logic [ROW_W-1:0] row;

  assign ref_req = seq_idle && (init_active || pend_nz);
  assign start   = ref_req && ref_gnt;
  assign accept  = start && init_done;
  assign we_n    = 1'b1;

  drs_init_ctl #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INIT_CYCLES (INIT_CYCLES)
  ) init_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_done    (cyc_done),
    .init_active (init_active),
    .init_done   (init_done)
  );

  drs_interval #(
    .REFI_CYC (REFI_CYC),
    .PEND_MAX (PEND_MAX)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (init_done),
    .accept   (accept),
    .pend_nz  (pend_nz),
    .miss_err (miss_err)
  );

  drs_row_ctr #(
    .ROWS  (ROWS),
    .ROW_W (ROW_W)
  ) row_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (cyc_done && ro_cycle),
    .row   (row)
  );

  drs_strobe_seq #(
    .ROW_W (ROW_W),
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_ro  (mode_ro),
    .row      (row),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .bus_own  (bus_own),
    .addr     (addr),
    .idle     (seq_idle),
    .cyc_done (cyc_done),
    .ro_cycle (ro_cycle)
  );

endmodule

// File: rtl/drs_chk.sv
// Port-level protocol checker, bound to the sequencer top.
module drs_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             bus_own,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             init_done,
  input logic             miss_err
);

  a_r12_released_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n && we_n && (addr == '0)));

  a_r3_no_req_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> !ref_req);

  a_r3_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(ref_req && ref_gnt));

  a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  a_r5_cas_falls_in_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  a_r6_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> ($past(addr) == addr));

  a_r4_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |=> miss_err);

endmodule

bind dram_refresh_seq drs_chk #(.ROW_W(ROW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_req   (ref_req),
  .ref_gnt   (ref_gnt),
  .bus_own   (bus_own),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .init_done (init_done),
  .miss_err  (miss_err)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;

  localparam int ROWS    = 16;
  localparam int REFI    = 40;
  localparam int PAUSE   = 25;
  localparam int NINIT   = 8;
  localparam int PMAX    = 2;
  localparam int T_CSR   = 1;
  localparam int T_CHR   = 2;
  localparam int T_RAS   = 3;
  localparam int T_RP    = 2;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int LEN     = T_CSR + T_RAS + T_RP;
  localparam int VW      = ROW_W + 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode_ro;
  logic             ref_gnt;
  logic             ref_req;
  logic             bus_own;
  logic             ras_n;
  logic             cas_n;
  logic             we_n;
  logic [ROW_W-1:0] addr;
  logic             init_done;
  logic             miss_err;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .ROWS (ROWS), .REFI_CYC (REFI), .PAUSE_CYC (PAUSE), .INIT_CYCLES (NINIT),
    .PEND_MAX (PMAX), .T_CSR (T_CSR), .T_CHR (T_CHR), .T_RAS (T_RAS), .T_RP (T_RP)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .mode_ro (mode_ro), .ref_gnt (ref_gnt),
    .ref_req (ref_req), .bus_own (bus_own), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .addr (addr), .init_done (init_done), .miss_err (miss_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] exp_vec(input int i, input bit ro, input int row);
    bit setup, act, cas_low;
    setup   = (i < T_CSR);
    act     = (i >= T_CSR) && (i < T_CSR + T_RAS);
    cas_low = !ro && (setup || (act && (i - T_CSR) < T_CHR));
    return {1'b1, 1'b0, !act, !cas_low, 1'b1, (ro ? ROW_W'(row) : ROW_W'(0))};
  endfunction

  // One granted refresh cycle, sampled at every negedge it owns the bus.
  task automatic run_cycle(input bit ro, input int row, input bit flip, input string tag);
    while (!ref_req) @(negedge clk);
    mode_ro = ro;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk("R3", 32'(bus_own), 32'd1);
    for (int i = 0; i < LEN; i++) begin
      chk(tag, 32'({bus_own, ref_req, ras_n, cas_n, we_n, addr}), 32'(exp_vec(i, ro, row)));
      if (flip && i == 1) mode_ro = !ro;
      @(negedge clk);
    end
    mode_ro = ro;
    chk("R12", 32'({bus_own, ras_n, cas_n, we_n, addr}), 32'({1'b0, 1'b1, 1'b1, 1'b1, ROW_W'(0)}));
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog act=timeout exp=done");
    finish_up();
  end

  initial begin
    int n;
    int rises;
    bit own_seen;
    bit prev_own;
    rst_n   = 1'b0;
    mode_ro = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset and after release
    chk("R1", 32'({bus_own, ref_req, ras_n, cas_n, we_n, addr, init_done, miss_err}),
        32'({1'b0, 1'b0, 1'b1, 1'b1, 1'b1, ROW_W'(0), 1'b0, 1'b0}));
    rst_n = 1'b1;
    chk("R1", 32'({bus_own, ref_req, ras_n, cas_n, we_n, addr, init_done, miss_err}),
        32'({1'b0, 1'b0, 1'b1, 1'b1, 1'b1, ROW_W'(0), 1'b0, 1'b0}));

    // R2: pause length, grant held high the whole time
    ref_gnt  = 1'b1;
    n        = 0;
    own_seen = 1'b0;
    while (!ref_req && n < PAUSE + 10) begin
      @(negedge clk);
      n++;
      if (bus_own) own_seen = 1'b1;
    end
    ref_gnt = 1'b0;
    chk("R2", 32'(n), 32'(PAUSE));
    chk("R2", 32'(own_seen), 32'd0);

    // R4 / R5: warm-up cycles with the device counting rows
    for (int k = 0; k < NINIT; k++) begin
      run_cycle(1'b0, 0, 1'b0, "R5");
      chk("R4", 32'(init_done), 32'(k == NINIT - 1));
    end

    // R9: first timer request
    n = 0;
    while (!ref_req && n < REFI + 10) begin
      @(negedge clk);
      n++;
    end
    chk("R9", 32'(n), 32'(REFI));

    // R11: backlog overflow with the grant withheld
    for (int c = 1; c <= PMAX * REFI; c++) begin
      @(negedge clk);
      if (c == PMAX * REFI - 1) chk("R11", 32'(miss_err), 32'd0);
      if (c == PMAX * REFI)     chk("R11", 32'(miss_err), 32'd1);
    end

    // R10: drain the queued refreshes back to back
    ref_gnt  = 1'b1;
    rises    = 0;
    prev_own = bus_own;
    for (int w = 0; w < PMAX * (LEN + 1) + 3; w++) begin
      @(negedge clk);
      if (bus_own && !prev_own) rises++;
      prev_own = bus_own;
    end
    ref_gnt = 1'b0;
    chk("R10", 32'(rises), 32'(PMAX));
    chk("R10", 32'(ref_req), 32'd0);
    chk("R11", 32'(miss_err), 32'd1);

    // R8: device-counted cycle with mode flipped mid-cycle
    run_cycle(1'b0, 0, 1'b1, "R8");

    // R6 / R7: row-addressed cycles, one lap plus a wrap
    for (int k = 0; k < ROWS + 4; k++) begin
      if (k == 3)         run_cycle(1'b1, k % ROWS, 1'b1, "R8");
      else if (k == ROWS) run_cycle(1'b1, k % ROWS, 1'b0, "R7");
      else                run_cycle(1'b1, k % ROWS, 1'b0, "R6");
    end

    finish_up();
  end

endmodule